// File: doc/BRIEF.md
# Per-CPU Interrupt Level Controller

This block sits beside one processor and turns several interrupt sources into fifteen independent processor-interrupt-level (PIL) lines, numbered 1 to 15. It keeps a 32-bit local pending word. The upper fifteen bits are software interrupts that the processor raises and drops through a small register window. Bit 15 holds a level-15 event broadcast to every processor. Bit 14 mirrors a local timer line. Bits 13 to 1 show the hard levels that the system-wide router delivers to this processor.

Each software bit sits sixteen places above the level it drives, and it reaches its PIL line through that fixed shift. The timer bit, the level-15 bit and the routed hard levels are blocked only by one global disable input. The software bits are never blocked. The router that picks a target processor and masks individual sources lives outside this block. The block receives from it only a target flag and a vector of hard levels.

The register window decodes byte offsets on a simple one-cycle bus. Offset 0x0 reads the pending word. Offset 0x4 clears bits where the written data has ones. Offset 0x8 sets bits where the written data has ones. Only full 32-bit, word-aligned accesses take effect.

Top module: `cpu_irq_level_ctl`

## Requirements
- R1: While `rst_n` is low, the next clock edge clears the pending word and the level-15 edge history, and `pil_out` reads 0.
- R2: A full-width, aligned read at offset 0x0 returns the pending word on `bus_rdata` in the same cycle. A read at any other offset, a read without `bus_full`, and any cycle without a read all return 0.
- R3: A full-width, aligned write at offset 0x8 ORs `bus_wdata & 0xFFFE0000` into the pending word at the next clock edge. It has no effect on bits 16 to 0.
- R4: A full-width, aligned write at offset 0x4 clears the pending bits selected by `bus_wdata & 0xFFFE8000`. Bit 14 and bits 13 to 1 are not affected.
- R5: A write to offset 0x0 or 0xC, a write with `bus_addr[1:0]` non-zero, and a write without `bus_full` all leave the pending word unchanged.
- R6: `pil_out[0]` is always 0. For k = 1 to 15, pending bit k+16 drives `pil_out[k]`.
- R7: Pending bit 14 takes the value of `timer_in` at each clock edge, and software writes cannot change it. When `glb_disable` is low, bit 14 drives `pil_out[14]`.
- R8: A rising edge on `l15_in` sets pending bit 15, and a falling edge clears it. When a rising edge and a software clear of bit 15 meet in the same cycle, the bit is set. When `glb_disable` is low, bit 15 drives `pil_out[15]`.
- R9: At each clock edge, pending bits 13 to 1 are rebuilt as `hard_lvl` when `is_target` is high, and as 0 when it is low. When `glb_disable` is low, each of these bits drives the PIL line of the same number.
- R10: When `glb_disable` is high, pending bits 15 to 1 drive no PIL line, while the software bits still drive theirs. `pil_out` responds to `glb_disable` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | Access is a full 32-bit word |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| timer_in | input | 1 | Local timer level |
| l15_in | input | 1 | Level-15 broadcast level |
| is_target | input | 1 | This processor receives the routed hard levels |
| hard_lvl | input | 13 | Routed hard levels 13 to 1 (bit 1 is the lowest) |
| glb_disable | input | 1 | Global disable for the timer, level 15 and hard levels |
| pil_out | output | 16 | PIL lines; bit k is level k, bit 0 is tied to 0 |

## Verification
The bench attacks the corner cases where a plausible design goes wrong:
- A clear of bit 15 in the same cycle as a level-15 rising edge. A design that gives priority to software would lose a broadcast event.
- A clear write with all ones. A design with a wrong clear mask would drop the timer mirror or the hard-level display.
- Misaligned, partial-width and stray-offset accesses. A loose decoder would change state on these or return data for them.
- The global disable with software bits pending. A design that masks too much would silence the software levels, and one that masks too little would let the timer through.
- Toggling of the target flag. A design that accumulates hard levels instead of rebuilding them would keep stale bits.

// File: rtl/ilc_pkg.sv
// Package: shared offsets and field positions for the per-CPU interrupt
// level controller. Assumes a 32-bit pending word split as soft / l15 /
// timer / hard-display fields.
package ilc_pkg;
    typedef enum logic [1:0] {
        OFS_PEND = 2'd0,
        OFS_CLR  = 2'd1,
        OFS_SET  = 2'd2,
        OFS_NONE = 2'd3
    } ilc_ofs_e;
endpackage

// File: rtl/ilc_bus_dec.sv
// Module: ilc_bus_dec
// Decodes one bus access per cycle into a set mask, a clear mask and a read
// hit. Assumes byte addressing with word index in the upper address bits;
// only full, aligned accesses take effect.
module ilc_bus_dec #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int SOFT_LO = 17,
    parameter int L15_BIT = 15
) (
    input  logic              sel,
    input  logic              we,
    input  logic              full,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] set_mask,
    output logic [DATA_W-1:0] clr_mask,
    output logic              rd_hit
);
    import ilc_pkg::*;

    logic [DATA_W-1:0] soft_bits;
    logic              ok;
    ilc_ofs_e          ofs;

    // Build the field masks from the parameters.
    always_comb begin
        soft_bits = '0;
        for (int i = SOFT_LO; i < DATA_W; i++) soft_bits[i] = 1'b1;
    end

    // Qualify the access and pick the register.
    always_comb begin
        ok  = sel && full && (addr[1:0] == 2'b00);
        ofs = ilc_ofs_e'(addr[3:2]);
    end

    // Produce the per-bit set and clear strobes and the read hit.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        rd_hit   = ok && !we && (ofs == OFS_PEND);
        if (ok && we && ofs == OFS_SET) set_mask = wdata & soft_bits;
        if (ok && we && ofs == OFS_CLR) begin
            clr_mask          = wdata & soft_bits;
            clr_mask[L15_BIT] = wdata[L15_BIT];
        end
    end
endmodule

// File: rtl/ilc_pend_reg.sv
// Module: ilc_pend_reg
// Holds the pending word. Soft bits are set or cleared by strobes, bit 15
// follows level-15 edges (edge beats software clear), bit 14 mirrors the
// timer, hard display bits are rebuilt each cycle.
module ilc_pend_reg #(
    parameter int DATA_W   = 32,
    parameter int SOFT_LO  = 17,
    parameter int L15_BIT  = 15,
    parameter int TMR_BIT  = 14,
    parameter int HARD_TOP = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   set_mask,
    input  logic [DATA_W-1:0]   clr_mask,
    input  logic                timer_in,
    input  logic                l15_in,
    input  logic                is_target,
    input  logic [HARD_TOP:1]   hard_lvl,
    output logic [DATA_W-1:0]   pend_q
);
    logic [DATA_W-1:0] pend_d;
    logic              l15_prev_q;

    // Compute the next pending word field by field.
    always_comb begin
        pend_d = '0;
        for (int i = SOFT_LO; i < DATA_W; i++)
            pend_d[i] = (pend_q[i] & ~clr_mask[i]) | set_mask[i];
        if (l15_in && !l15_prev_q)
            pend_d[L15_BIT] = 1'b1;
        else if (!l15_in && l15_prev_q)
            pend_d[L15_BIT] = 1'b0;
        else
            pend_d[L15_BIT] = pend_q[L15_BIT] & ~clr_mask[L15_BIT];
        pend_d[TMR_BIT] = timer_in;
        for (int i = 1; i <= HARD_TOP; i++)
            pend_d[i] = is_target & hard_lvl[i];
    end

    // Register the pending word and the level-15 history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            l15_prev_q <= 1'b0;
        end else begin
            pend_q     <= pend_d;
            l15_prev_q <= l15_in;
        end
    end
endmodule

// File: rtl/ilc_pil_merge.sv
// Module: ilc_pil_merge
// Folds the shifted soft bits and the gated low field into PIL lines.
// Assumes line 0 does not exist.
module ilc_pil_merge #(
    parameter int NUM_PIL = 16
) (
    input  logic [NUM_PIL-2:0] soft_f,
    input  logic [NUM_PIL-2:0] low_f,
    input  logic               glb_disable,
    output logic [NUM_PIL-1:0] pil
);
    // One OR gate per line; the low field is blocked by the global disable.
    always_comb begin
        pil[0] = 1'b0;
        for (int k = 1; k < NUM_PIL; k++)
            pil[k] = soft_f[k-1] | (low_f[k-1] & ~glb_disable);
    end
endmodule

// File: rtl/cpu_irq_level_ctl.sv
// Module: cpu_irq_level_ctl
// Top of the per-CPU interrupt level controller: bus decode, pending word
// and PIL merge. Assumes one bus access per cycle and a router outside.
module cpu_irq_level_ctl #(
    parameter int NUM_PIL = 16,
    parameter int ADDR_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic                 bus_full,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 timer_in,
    input  logic                 l15_in,
    input  logic                 is_target,
    input  logic [NUM_PIL-4:0]   hard_lvl,
    input  logic                 glb_disable,
    output logic [NUM_PIL-1:0]   pil_out
);
    localparam int SOFT_OFS = NUM_PIL;
    localparam int DATA_W   = 2 * NUM_PIL;
    localparam int SOFT_LO  = SOFT_OFS + 1;
    localparam int L15_BIT  = NUM_PIL - 1;
    localparam int TMR_BIT  = NUM_PIL - 2;
    localparam int HARD_TOP = NUM_PIL - 3;

    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] pend_q;
    logic              rd_hit;
    logic [HARD_TOP:1] hard_r;

    // Re-index the hard levels so bit k means level k.
    assign hard_r = hard_lvl;

    ilc_bus_dec #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SOFT_LO(SOFT_LO), .L15_BIT(L15_BIT)
    ) u_dec (
        .sel(bus_sel), .we(bus_we), .full(bus_full), .addr(bus_addr),
        .wdata(bus_wdata), .set_mask(set_mask), .clr_mask(clr_mask),
        .rd_hit(rd_hit)
    );

    ilc_pend_reg #(
        .DATA_W(DATA_W), .SOFT_LO(SOFT_LO), .L15_BIT(L15_BIT),
        .TMR_BIT(TMR_BIT), .HARD_TOP(HARD_TOP)
    ) u_pend (
        .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
        .timer_in(timer_in), .l15_in(l15_in), .is_target(is_target),
        .hard_lvl(hard_r), .pend_q(pend_q)
    );

    ilc_pil_merge #(.NUM_PIL(NUM_PIL)) u_merge (
        .soft_f(pend_q[DATA_W-1:SOFT_LO]),
        .low_f(pend_q[L15_BIT:1]),
        .glb_disable(glb_disable),
        .pil(pil_out)
    );

    // Return the pending word only on a qualified read.
    assign bus_rdata = rd_hit ? pend_q : '0;
endmodule

// File: rtl/ilc_checker.sv
// Module: ilc_checker
// Temporal checks on the controller's ports and pending word, bound to the top.
module ilc_checker #(
    parameter int NUM_PIL = 16,
    parameter int ADDR_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic                 bus_full,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [31:0]          bus_rdata,
    input  logic                 timer_in,
    input  logic                 l15_in,
    input  logic                 is_target,
    input  logic [NUM_PIL-4:0]   hard_lvl,
    input  logic                 glb_disable,
    input  logic [NUM_PIL-1:0]   pil_out,
    input  logic [2*NUM_PIL-1:0] pend_q
);
    localparam int DATA_W  = 2 * NUM_PIL;
    localparam int SOFT_LO = NUM_PIL + 1;
    localparam logic [31:0] SOFT_M = 32'hFFFE_0000;

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && pil_out == '0));

    a_r2_stray_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (bus_addr != '0 || !bus_full)) |-> bus_rdata == '0);

    a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_full && bus_addr == 4'h8)
        |=> ((pend_q & ($past(bus_wdata) & SOFT_M)) == ($past(bus_wdata) & SOFT_M)));

    a_r6_no_level0: assert property (@(posedge clk) disable iff (!rst_n)
        pil_out[0] == 1'b0);

    a_r7_timer_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pend_q[NUM_PIL-2] == $past(timer_in));

    a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l15_in) |=> pend_q[NUM_PIL-1]);

    a_r9_target_copy: assert property (@(posedge clk) disable iff (!rst_n)
        is_target |=> pend_q[NUM_PIL-3:1] == $past(hard_lvl));

    a_r9_nontarget_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !is_target |=> pend_q[NUM_PIL-3:1] == '0);

    a_r10_soft_only: assert property (@(posedge clk) disable iff (!rst_n)
        glb_disable |-> pil_out[NUM_PIL-1:1] == pend_q[DATA_W-1:SOFT_LO]);
endmodule

bind cpu_irq_level_ctl ilc_checker #(.NUM_PIL(NUM_PIL), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .timer_in(timer_in), .l15_in(l15_in),
    .is_target(is_target), .hard_lvl(hard_lvl), .glb_disable(glb_disable),
    .pil_out(pil_out), .pend_q(pend_q)
);

// File: tb/cpu_irq_level_ctl_tb.sv
// Bench: behavioural model updated on every rising edge, compared a quarter
// period later; directed phases add fixed expected values.
module cpu_irq_level_ctl_tb;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, bus_full = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        timer_in = 1'b0, l15_in = 1'b0, is_target = 1'b0;
    logic [12:0] hard_lvl = '0;
    logic        glb_disable = 1'b0;
    logic [15:0] pil_out;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic [31:0] m_pend = '0;
    logic        m_prev = 1'b0;

    cpu_irq_level_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .timer_in(timer_in), .l15_in(l15_in),
        .is_target(is_target), .hard_lvl(hard_lvl), .glb_disable(glb_disable),
        .pil_out(pil_out)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_pil(logic [31:0] p, logic dis);
        logic [15:0] r;
        r = p[31:16] | (dis ? 16'h0 : p[15:0]);
        r[0] = 1'b0;
        return r;
    endfunction

    // Reference model and per-cycle comparison.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0;
            m_prev = 1'b0;
        end else begin
            logic ok;
            ok = bus_sel && bus_we && bus_full && bus_addr[1:0] == 2'b00;
            if (ok && bus_addr[3:2] == 2'd2) m_pend = m_pend | (bus_wdata & 32'hFFFE0000);
            if (ok && bus_addr[3:2] == 2'd1) m_pend = m_pend & ~(bus_wdata & 32'hFFFE8000);
            if (l15_in && !m_prev) m_pend[15] = 1'b1;
            else if (!l15_in && m_prev) m_pend[15] = 1'b0;
            m_pend[14] = timer_in;
            m_pend[13:1] = is_target ? hard_lvl : 13'h0;
            m_pend[16] = 1'b0;
            m_pend[0] = 1'b0;
            m_prev = l15_in;
        end
        #(CLK_T/4);
        chk({cur_req, " pil"}, {16'h0, pil_out}, {16'h0, exp_pil(m_pend, glb_disable)});
        chk({cur_req, " rdata"}, bus_rdata,
            (bus_sel && !bus_we && bus_full && bus_addr == 4'h0) ? m_pend : 32'h0);
    end

    // Called just after a falling edge: one write cycle.
    task automatic bus_wr(logic [3:0] a, logic [31:0] d, logic full);
        bus_sel = 1'b1; bus_we = 1'b1; bus_full = full; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_full = 1'b0; bus_wdata = '0; bus_addr = '0;
    endtask

    // Called just after a falling edge: combinational read and fixed check.
    task automatic rd_chk(logic [3:0] a, logic full, logic [31:0] exp, string req);
        bus_sel = 1'b1; bus_we = 1'b0; bus_full = full; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        bus_sel = 1'b0; bus_full = 1'b0; bus_addr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        rd_chk(4'h0, 1'b1, 32'h0, "R1 reset pending");
        chk("R1 reset pil", {16'h0, pil_out}, 32'h0);

        cur_req = "R3";
        bus_wr(4'h8, 32'hFFFF_FFFF, 1'b1);
        rd_chk(4'h0, 1'b1, 32'hFFFE_0000, "R3 set masks low bits");

        cur_req = "R4";
        bus_wr(4'h4, 32'h000A_0000, 1'b1);
        rd_chk(4'h0, 1'b1, 32'hFFF4_0000, "R4 clear selected soft bits");

        cur_req = "R5";
        bus_wr(4'hC, 32'hFFFF_FFFF, 1'b1);
        bus_wr(4'h4, 32'hFFFF_FFFF, 1'b0);
        bus_wr(4'h6, 32'hFFFF_FFFF, 1'b1);
        bus_wr(4'h0, 32'hFFFF_FFFF, 1'b1);
        rd_chk(4'h0, 1'b1, 32'hFFF4_0000, "R5 ignored writes");

        cur_req = "R2";
        rd_chk(4'h4, 1'b1, 32'h0, "R2 read at clear offset");
        rd_chk(4'h0, 1'b0, 32'h0, "R2 partial read");
        rd_chk(4'h8, 1'b1, 32'h0, "R2 read at set offset");

        cur_req = "R6";
        #1 chk("R6 soft to pil", {16'h0, pil_out}, 32'h0000_FFF4);
        @(negedge clk);

        cur_req = "R7";
        bus_wr(4'h4, 32'hFFFF_FFFF, 1'b1);
        timer_in = 1'b1;
        @(negedge clk);
        rd_chk(4'h0, 1'b1, 32'h0000_4000, "R7 timer mirror");
        chk("R7 timer pil", {16'h0, pil_out}, 32'h0000_4000);
        bus_wr(4'h4, 32'h0000_4000, 1'b1);
        rd_chk(4'h0, 1'b1, 32'h0000_4000, "R4 clear leaves timer bit");

        cur_req = "R10";
        glb_disable = 1'b1;
        #1 chk("R10 disable hides timer", {16'h0, pil_out}, 32'h0);
        @(negedge clk);
        bus_wr(4'h8, 32'h0002_0000, 1'b1);
        #1 chk("R10 soft survives disable", {16'h0, pil_out}, 32'h0000_0002);
        glb_disable = 1'b0;
        timer_in = 1'b0;
        @(negedge clk);

        cur_req = "R8";
        bus_wr(4'h4, 32'hFFFF_FFFF, 1'b1);
        l15_in = 1'b1;
        bus_wr(4'h4, 32'h0000_8000, 1'b1);
        rd_chk(4'h0, 1'b1, 32'h0000_8000, "R8 edge beats clear");
        chk("R8 level15 pil", {16'h0, pil_out}, 32'h0000_8000);
        bus_wr(4'h4, 32'h0000_8000, 1'b1);
        rd_chk(4'h0, 1'b1, 32'h0, "R8 software clear while held");
        l15_in = 1'b0;
        @(negedge clk);
        l15_in = 1'b1;
        @(negedge clk);
        rd_chk(4'h0, 1'b1, 32'h0000_8000, "R8 second rise");
        l15_in = 1'b0;
        @(negedge clk);
        rd_chk(4'h0, 1'b1, 32'h0, "R8 fall clears");

        cur_req = "R9";
        is_target = 1'b1;
        hard_lvl = 13'h1555;
        @(negedge clk);
        rd_chk(4'h0, 1'b1, 32'h0000_2AAA, "R9 hard display");
        chk("R9 hard pil", {16'h0, pil_out}, 32'h0000_2AAA);
        hard_lvl = 13'h0AAA;
        @(negedge clk);
        rd_chk(4'h0, 1'b1, 32'h0000_1554, "R9 rebuilt not merged");
        is_target = 1'b0;
        @(negedge clk);
        rd_chk(4'h0, 1'b1, 32'h0, "R9 not target");
        hard_lvl = '0;

        cur_req = "R1";
        bus_wr(4'h8, 32'hF000_0000, 1'b1);
        timer_in = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        timer_in = 1'b0;
        rst_n = 1'b1;
        rd_chk(4'h0, 1'b1, 32'h0, "R1 reset mid-run");
        repeat (2) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_T * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule